// File: doc/BRIEF.md
# Look-Ahead XY Route Computation Unit

This unit sits at a mesh router input port, directly behind the flit buffer. Each flit it accepts already carries the one-hot output direction that the upstream router selected for it at this router. The unit forwards that direction unchanged as the switch request for the current cycle. In parallel it works out which router the flit will enter next. It then runs dimension-ordered XY routing from that neighbour and writes the resulting direction back into the flit. The downstream router can therefore arbitrate as soon as the flit arrives, without routing it first.

There is no head flit. Every flit carries its own destination and tail marker, and each flit is routed on its own. The unit is a single registered stage that does not depend on the switch arbiter's result, so it can run in the same cycle as arbitration.

A build option adds a sixth direction for one shortcut link. The link leaves a chosen host router and lands at a chosen endpoint router. With this option the direction field is one bit wider and so is the flit. A direction that would take a flit off the mesh raises an error flag.

Top module: `lar_route_unit`

## Requirements
- R1: The flit layout is: destination Y in bits [2:0], destination X in bits [5:3], direction field starting at bit 6 (5 bits wide, 6 with the shortcut option), then a 64-bit payload, then the tail flag in the top bit. Destination, payload and tail pass to the output unchanged.
- R2: Directions are one-hot. Bit 0 is Local, bit 1 North (Y+1), bit 2 East (X+1), bit 3 South (Y-1), bit 4 West (X-1), and bit 5 is the shortcut direction when that option is built.
- R3: The registered `out_req` equals the incoming direction field of the flit accepted in the previous cycle.
- R4: The next router is this router's coordinates stepped one hop in the incoming direction. Local means this router itself.
- R5: The rewritten direction is Local when the destination equals the next router. Otherwise it is East or West while X differs, and then North or South.
- R6: `out_valid` follows `in_valid` one cycle later. A cycle with `in_valid` low gives `out_valid` and `out_req` both 0 in the next cycle.
- R7: `out_err` is 1 and both `out_req` and the rewritten field are 0 when any of these holds: the incoming field is not exactly one-hot, its step leaves the 4x4 mesh, or the rewritten direction would leave the mesh. Destination, payload and tail still pass through.
- R8: With the shortcut option, the flit is 77 bits and the direction field is 6 bits. An incoming shortcut direction at the host router makes the endpoint the next router. At any other router it is an error.
- R9: With the shortcut option, the rewritten direction is the shortcut when the next router is the host and the destination equals the endpoint.
- R10: While reset is high, `out_valid`, `out_req` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A flit is presented this cycle |
| in_flit | input | FLIT_W (76, or 77 with shortcut) | Flit read from the input buffer |
| my_x | input | COORD_W | X coordinate of this router |
| my_y | input | COORD_W | Y coordinate of this router |
| out_valid | output | 1 | Registered flit is valid |
| out_flit | output | FLIT_W | Flit with rewritten direction field |
| out_req | output | NP_W | One-hot switch request for the current output |
| out_err | output | 1 | Illegal or off-mesh direction detected |

## Verification
The forwarded switch request and the rewritten look-ahead field come from the same flit and are registered in the same cycle. The bench streams every router position, every incoming direction and every 3-bit destination back to back, one flit per cycle. It judges both fields of each output word against arithmetic expectations. The sweep includes cases where the two fields coincide, such as an incoming Local with a Local result. It also includes cases where an off-mesh step or an off-mesh destination must blank both fields at once while the payload still passes.

// File: rtl/lar_pkg.sv
package lar_pkg;
  // one-hot direction bit positions, decoded by neighbouring routers
  localparam int unsigned DIR_LOCAL = 0;
  localparam int unsigned DIR_NORTH = 1;
  localparam int unsigned DIR_EAST  = 2;
  localparam int unsigned DIR_SOUTH = 3;
  localparam int unsigned DIR_WEST  = 4;
  localparam int unsigned DIR_EXTRA = 5;
  localparam int unsigned BASE_DIRS = 5;
endpackage

// File: rtl/lar_hop_step.sv
module lar_hop_step
  import lar_pkg::*;
#(
  parameter int COORD_W  = 3,
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  parameter int NP_W     = 5,
  parameter bit HAS_SC   = 1'b0,
  parameter int SC_SRC_X = 0,
  parameter int SC_SRC_Y = 0,
  parameter int SC_DST_X = 0,
  parameter int SC_DST_Y = 0
) (
  input  logic [NP_W-1:0]    dir,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  output logic [COORD_W-1:0] nxt_x,
  output logic [COORD_W-1:0] nxt_y,
  output logic               bad
);
  localparam logic [COORD_W-1:0] MAX_X = COORD_W'(MESH_X - 1);
  localparam logic [COORD_W-1:0] MAX_Y = COORD_W'(MESH_Y - 1);
  localparam logic [COORD_W-1:0] SRC_X = COORD_W'(SC_SRC_X);
  localparam logic [COORD_W-1:0] SRC_Y = COORD_W'(SC_SRC_Y);
  localparam logic [COORD_W-1:0] DST_X = COORD_W'(SC_DST_X);
  localparam logic [COORD_W-1:0] DST_Y = COORD_W'(SC_DST_Y);

  logic sc_sel;
  generate
    if (HAS_SC) begin : g_sc
      assign sc_sel = dir[DIR_EXTRA];
    end else begin : g_nosc
      assign sc_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt_x = cur_x;
    nxt_y = cur_y;
    bad   = 1'b0;
    if ($countones(dir) != 1) begin
      bad = 1'b1;
    end else if (dir[DIR_NORTH]) begin
      if (cur_y == MAX_Y) bad = 1'b1;
      else nxt_y = cur_y + COORD_W'(1);
    end else if (dir[DIR_EAST]) begin
      if (cur_x == MAX_X) bad = 1'b1;
      else nxt_x = cur_x + COORD_W'(1);
    end else if (dir[DIR_SOUTH]) begin
      if (cur_y == '0) bad = 1'b1;
      else nxt_y = cur_y - COORD_W'(1);
    end else if (dir[DIR_WEST]) begin
      if (cur_x == '0) bad = 1'b1;
      else nxt_x = cur_x - COORD_W'(1);
    end else if (sc_sel) begin
      if (cur_x == SRC_X && cur_y == SRC_Y) begin
        nxt_x = DST_X;
        nxt_y = DST_Y;
      end else begin
        bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lar_xy_pick.sv
module lar_xy_pick
  import lar_pkg::*;
#(
  parameter int COORD_W  = 3,
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  parameter int NP_W     = 5,
  parameter bit HAS_SC   = 1'b0,
  parameter int SC_SRC_X = 0,
  parameter int SC_SRC_Y = 0,
  parameter int SC_DST_X = 0,
  parameter int SC_DST_Y = 0
) (
  input  logic [COORD_W-1:0] at_x,
  input  logic [COORD_W-1:0] at_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [NP_W-1:0]    dir,
  output logic               bad
);
  localparam logic [COORD_W-1:0] MAX_X = COORD_W'(MESH_X - 1);
  localparam logic [COORD_W-1:0] MAX_Y = COORD_W'(MESH_Y - 1);
  localparam logic [NP_W-1:0]    EXTRA_OH = NP_W'(1) << (NP_W - 1);

  logic sc_hit;
  generate
    if (HAS_SC) begin : g_sc
      assign sc_hit = (at_x == COORD_W'(SC_SRC_X)) && (at_y == COORD_W'(SC_SRC_Y)) &&
                      (dst_x == COORD_W'(SC_DST_X)) && (dst_y == COORD_W'(SC_DST_Y));
    end else begin : g_nosc
      assign sc_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    dir = '0;
    bad = 1'b0;
    if (sc_hit) begin
      dir = EXTRA_OH;
    end else if (dst_x == at_x && dst_y == at_y) begin
      dir[DIR_LOCAL] = 1'b1;
    end else if (dst_x > at_x) begin
      if (at_x == MAX_X) bad = 1'b1;
      else dir[DIR_EAST] = 1'b1;
    end else if (dst_x < at_x) begin
      dir[DIR_WEST] = 1'b1;
    end else if (dst_y > at_y) begin
      if (at_y == MAX_Y) bad = 1'b1;
      else dir[DIR_NORTH] = 1'b1;
    end else begin
      dir[DIR_SOUTH] = 1'b1;
    end
  end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit
  import lar_pkg::*;
#(
  parameter int COORD_W   = 3,
  parameter int MESH_X    = 4,
  parameter int MESH_Y    = 4,
  parameter int PAYLOAD_W = 64,
  parameter bit HAS_SC    = 1'b0,
  parameter int SC_SRC_X  = 3,
  parameter int SC_SRC_Y  = 0,
  parameter int SC_DST_X  = 0,
  parameter int SC_DST_Y  = 3,
  localparam int NP_W     = HAS_SC ? BASE_DIRS + 1 : BASE_DIRS,
  localparam int FLIT_W   = 2 * COORD_W + NP_W + PAYLOAD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [FLIT_W-1:0]  in_flit,
  input  logic [COORD_W-1:0] my_x,
  input  logic [COORD_W-1:0] my_y,
  output logic               out_valid,
  output logic [FLIT_W-1:0]  out_flit,
  output logic [NP_W-1:0]    out_req,
  output logic               out_err
);
  localparam int NP_LSB = 2 * COORD_W;
  localparam int NP_MSB = NP_LSB + NP_W - 1;

  logic [NP_W-1:0]    in_dir, new_dir;
  logic [COORD_W-1:0] dst_x, dst_y, nxt_x, nxt_y;
  logic               step_bad, pick_bad, any_bad;
  logic [FLIT_W-1:0]  flit_d;

  assign dst_y  = in_flit[COORD_W-1:0];
  assign dst_x  = in_flit[2*COORD_W-1:COORD_W];
  assign in_dir = in_flit[NP_MSB:NP_LSB];

  lar_hop_step #(
    .COORD_W(COORD_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NP_W(NP_W), .HAS_SC(HAS_SC),
    .SC_SRC_X(SC_SRC_X), .SC_SRC_Y(SC_SRC_Y), .SC_DST_X(SC_DST_X), .SC_DST_Y(SC_DST_Y)
  ) u_step (
    .dir(in_dir), .cur_x(my_x), .cur_y(my_y),
    .nxt_x(nxt_x), .nxt_y(nxt_y), .bad(step_bad)
  );

  lar_xy_pick #(
    .COORD_W(COORD_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NP_W(NP_W), .HAS_SC(HAS_SC),
    .SC_SRC_X(SC_SRC_X), .SC_SRC_Y(SC_SRC_Y), .SC_DST_X(SC_DST_X), .SC_DST_Y(SC_DST_Y)
  ) u_pick (
    .at_x(nxt_x), .at_y(nxt_y), .dst_x(dst_x), .dst_y(dst_y),
    .dir(new_dir), .bad(pick_bad)
  );

  assign any_bad = step_bad | pick_bad;

  always_comb begin
    flit_d = in_flit;
    flit_d[NP_MSB:NP_LSB] = any_bad ? '0 : new_dir;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      out_req   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_flit <= flit_d;
        out_req  <= any_bad ? '0 : in_dir;
        out_err  <= any_bad;
      end else begin
        out_req  <= '0;
        out_err  <= 1'b0;
      end
    end
  end

  // R10: reset clears the handshake outputs
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_req == '0 && !out_err));

  // R6: one-cycle valid latency and quiet idle cycles
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && out_req == '0 && !out_err));

  // R3: the request is the upstream-chosen direction, not recomputed
  assert_req_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !any_bad) |=> (out_req == $past(in_dir)));

  // R1: everything outside the direction field is carried through
  assert_fields_pass_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_flit[FLIT_W-1:NP_MSB+1] == $past(in_flit[FLIT_W-1:NP_MSB+1]) &&
                  out_flit[NP_LSB-1:0] == $past(in_flit[NP_LSB-1:0])));

  // R5: a good flit leaves with exactly one look-ahead direction
  assert_new_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> ($countones(out_flit[NP_MSB:NP_LSB]) == 1 &&
                                 $countones(out_req) == 1));

  // R7: an error blanks both the request and the rewritten field
  assert_err_blank_R7: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_req == '0 && out_flit[NP_MSB:NP_LSB] == '0 && out_valid));
endmodule

// File: tb/lar_route_unit_test.sv
`timescale 1ns/1ps
module lar_route_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // plain build: 76-bit flit, 5-bit directions
  logic        in_valid = 1'b0;
  logic [75:0] in_flit  = '0;
  logic [2:0]  my_x = '0, my_y = '0;
  logic        out_valid, out_err;
  logic [75:0] out_flit;
  logic [4:0]  out_req;

  lar_route_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .my_x(my_x), .my_y(my_y), .out_valid(out_valid), .out_flit(out_flit),
    .out_req(out_req), .out_err(out_err)
  );

  // shortcut build: host (3,0), endpoint (0,3), 77-bit flit
  logic        s_valid = 1'b0;
  logic [76:0] s_flit  = '0;
  logic [2:0]  s_x = '0, s_y = '0;
  logic        s_ovalid, s_oerr;
  logic [76:0] s_oflit;
  logic [5:0]  s_oreq;

  lar_route_unit #(.HAS_SC(1'b1), .SC_SRC_X(3), .SC_SRC_Y(0), .SC_DST_X(0), .SC_DST_Y(3)) uut_sc (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_flit(s_flit),
    .my_x(s_x), .my_y(s_y), .out_valid(s_ovalid), .out_flit(s_oflit),
    .out_req(s_oreq), .out_err(s_oerr)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one flit into the plain build and check it a cycle later
  task automatic run_plain(input int mx, input int myy, input logic [4:0] dir,
                           input int dx, input int dy, input int k);
    int nx, ny, bad;
    logic [4:0]  ereq, enp;
    logic [63:0] pay;
    logic        tl;
    pay = {32'(k) * 32'h9E3779B1, 32'(k) ^ 32'hA5A50F0F};
    tl  = k[0];
    @(negedge clk);
    in_valid = 1'b1;
    my_x = 3'(mx); my_y = 3'(myy);
    in_flit = {tl, pay, dir, 3'(dx), 3'(dy)};
    // model: step (R4), then XY from the neighbour (R5), mesh limits (R7)
    nx = mx; ny = myy; bad = 0;
    case (dir)
      5'b00001: ;
      5'b00010: if (myy == 3) bad = 1; else ny = myy + 1;
      5'b00100: if (mx == 3) bad = 1; else nx = mx + 1;
      5'b01000: if (myy == 0) bad = 1; else ny = myy - 1;
      5'b10000: if (mx == 0) bad = 1; else nx = mx - 1;
      default:  bad = 1;
    endcase
    enp = '0;
    if (dx == nx && dy == ny) enp = 5'b00001;
    else if (dx > nx) begin if (nx == 3) bad = 1; else enp = 5'b00100; end
    else if (dx < nx) enp = 5'b10000;
    else if (dy > ny) begin if (ny == 3) bad = 1; else enp = 5'b00010; end
    else enp = 5'b01000;
    if (bad != 0) enp = '0;
    ereq = (bad != 0) ? 5'b0 : dir;
    @(posedge clk); #1;
    chk("R6 valid", 128'(out_valid), 128'(1'b1));
    chk("R1 fields", 128'({out_flit[75:11], out_flit[5:0]}), 128'({tl, pay, 3'(dx), 3'(dy)}));
    chk("R3 req", 128'(out_req), 128'(ereq));
    chk("R5 newdir", 128'(out_flit[10:6]), 128'(enp));
    chk("R7 err", 128'(out_err), 128'(bad != 0));
  endtask

  task automatic run_sc(input string tag, input int mx, input int myy, input logic [5:0] dir,
                        input int dx, input int dy, input logic [5:0] ereq,
                        input logic [5:0] enp, input logic eerr);
    logic [63:0] pay;
    pay = 64'hC0FFEE00_12345678 ^ 64'(mx * 97 + dx);
    @(negedge clk);
    s_valid = 1'b1;
    s_x = 3'(mx); s_y = 3'(myy);
    s_flit = {1'b1, pay, dir, 3'(dx), 3'(dy)};
    @(posedge clk); #1;
    chk(tag, 128'({s_oreq, s_oflit[11:6], s_oerr}), 128'({ereq, enp, eerr}));
    chk("R8 width", 128'({s_oflit[76:12], s_oflit[5:0]}), 128'({1'b1, pay, 3'(dx), 3'(dy)}));
  endtask

  initial begin
    int k = 0;
    in_valid = 1'b1;  // present a flit during reset: must not show
    in_flit  = {1'b1, 64'hFFFF, 5'b00100, 3'd2, 3'd2};
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset", 128'({out_valid, out_req, out_err, s_ovalid, s_oreq, s_oerr}), 128'(0));
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    // R2: encoding, router (1,1) North to (1,2), destination (1,3) -> North
    run_plain(1, 1, 5'b00010, 1, 3, 1);
    // R4: West from (2,2) reaches (1,2); destination (1,0) -> South
    run_plain(2, 2, 5'b10000, 1, 0, 2);
    // R7: malformed incoming fields
    run_plain(1, 1, 5'b00011, 2, 2, 3);
    run_plain(1, 1, 5'b00000, 2, 2, 4);

    // exhaustive back-to-back sweep over routers, directions, destinations
    for (int mx = 0; mx < 4; mx++)
      for (int myy = 0; myy < 4; myy++)
        for (int p = 0; p < 5; p++)
          for (int dx = 0; dx < 8; dx++)
            for (int dy = 0; dy < 8; dy++) begin
              k++;
              run_plain(mx, myy, 5'(1 << p), dx, dy, k);
            end

    // R6: an idle cycle after the stream
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R6 idle", 128'({out_valid, out_req, out_err}), 128'(0));

    // R8: shortcut taken into the endpoint, and misuse at a non-host
    run_sc("R8 extra in", 3, 0, 6'b100000, 0, 0, 6'b100000, 6'b001000, 1'b0);
    run_sc("R8 extra in", 3, 0, 6'b100000, 0, 3, 6'b100000, 6'b000001, 1'b0);
    run_sc("R8 extra bad", 1, 1, 6'b100000, 0, 3, 6'b000000, 6'b000000, 1'b1);
    // R9: shortcut chosen only for the endpoint destination at the host
    run_sc("R9 pick extra", 2, 0, 6'b000100, 0, 3, 6'b000100, 6'b100000, 1'b0);
    run_sc("R9 pick extra", 3, 1, 6'b001000, 0, 3, 6'b001000, 6'b100000, 1'b0);
    run_sc("R9 plain xy", 2, 0, 6'b000100, 0, 2, 6'b000100, 6'b010000, 1'b0);
    run_sc("R9 plain xy", 1, 0, 6'b000100, 0, 3, 6'b000100, 6'b010000, 1'b0);
    @(negedge clk);
    s_valid = 1'b0;
    @(posedge clk); #1;
    chk("R6 idle sc", 128'({s_ovalid, s_oreq, s_oerr}), 128'(0));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule